// File: doc/BRIEF.md
# Sequential and Nested Priority Interrupt Controller

This block collects interrupt requests from a small set of sources (program exceptions, a timer, I/O controllers, a hardware-failure detector) and offers one request with a binary vector to a processor. The processor accepts the offered request with an acknowledge pulse. It tells the controller that the handler has finished with an end-of-service pulse.

A mode input selects one of two service disciplines. In sequential mode only one source is ever in service. Requests that arrive during that service stay latched, and they are offered later in the order they arrived. In nested mode a source of higher priority than the one in service is offered at once and may preempt it. When that service ends, the controller reports the preempted level as active again. The top of the in-service stack is visible on two outputs, so the processor can tell which level it has returned to.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `cpu_irq` is 0, `cpu_vec` is 0 and `svc_active` is 0.
- R2: A source is latched as pending on a 0-to-1 transition of its `irq_src` bit. A line held high after it has been acknowledged is not latched again until it falls and rises.
- R3: `cpu_vec` is the binary index of the offered source (0 to NSRC-1) while `cpu_irq` is 1, and is 0 while `cpu_irq` is 0.
- R4: In sequential mode (`mode_nested`=0), `cpu_irq` stays 0 while `svc_active` is 1, and requests raised during that time stay pending.
- R5: In sequential mode, pending sources are offered one at a time in the order their rising edges occurred.
- R6: In sequential mode, sources whose edges fall in the same cycle are queued with the higher index first.
- R7: In nested mode (`mode_nested`=1), a pending source is offered while another is in service only if its index is greater than `svc_level`. An equal or lower index waits.
- R8: `cpu_eoi` removes the highest level from service. In nested mode `svc_level` then shows the preempted level, and `svc_active` falls once no level remains.
- R9: `cpu_ack` while `cpu_irq` is 1 moves the offered source from pending into service, so that `svc_level` equals that vector in the next cycle. `cpu_ack` while `cpu_irq` is 0 has no effect.
- R10: In nested mode with no level in service, the pending source with the highest index is offered.
- R11: In a cycle with neither an accepted acknowledge nor `cpu_eoi`, `svc_active` and `svc_level` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_nested | input | 1 | 0 = sequential arrival-order service, 1 = nested priority service |
| irq_src | input | NSRC | Request line per source; index NSRC-1 has highest priority |
| cpu_irq | output | 1 | Request to the processor |
| cpu_vec | output | VW | Index of the offered source |
| cpu_ack | input | 1 | Processor accepts the offered source |
| cpu_eoi | input | 1 | Processor finished the current service |
| svc_active | output | 1 | At least one level is in service |
| svc_level | output | VW | Highest level in service |

## Verification
A damaged arrival queue shows up in sequential mode as a vector that does not match the order of the edges. The bench catches it at the first offer after the queue is written, because it tries every arrival order of the four sources and every set of simultaneous edges. A wrong in-service stack shows at `svc_level` in the cycle after an end-of-service, or as a request that is wrongly offered or wrongly held back. Every ordered pair of a running level and a newly arriving level is covered. A wrong pending bit appears as a request that is missing or added one cycle after the edge or the acknowledge.

// File: rtl/irq_nest_pkg.sv
// Package: shared service-mode encoding for the interrupt controller.
// Assumes: one mode bit, driven from a static configuration input.
package irq_nest_pkg;

    typedef enum logic {
        SVC_SEQUENTIAL = 1'b0,
        SVC_NESTED     = 1'b1
    } svc_mode_e;

endpackage

// File: rtl/irq_edge_det.sv
// Module: registers the request lines and flags the 0-to-1 transitions.
// Assumes: request lines are synchronous to clk. A line already high when
// reset is released reports an edge on the first clock.
module irq_edge_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] lvl_q;

    // Hold the previous line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    // A rising edge is a line that is high now and was low before.
    always_comb rise = lvl & ~lvl_q;

endmodule

// File: rtl/irq_prio_enc.sv
// Module: finds the highest set bit of a vector and returns it as an index
// and as a one-hot mask.
// Assumes: N >= 2. The outputs are 0 when no bit is set.
module irq_prio_enc #(
    parameter int N = 4,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx,
    output logic [N-1:0] onehot
);

    // Scan upward so that the highest set bit wins.
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) idx = W'(i);
        end
        onehot = any ? (N'(1) << idx) : '0;
    end

endmodule

// File: rtl/irq_arrival_queue.sv
// Module: keeps source indices in arrival order. Any entry can be removed,
// and the entries behind it close up the gap. Several sources can be
// appended in one cycle, the highest index first.
// Assumes: a source is never queued twice, because the caller pushes only
// sources that are not yet pending. DEPTH >= N therefore never overflows.
module irq_arrival_queue #(
    parameter int N     = 4,
    parameter int W     = $clog2(N),
    parameter int DEPTH = N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] push_mask,
    input  logic         rm_en,
    input  logic [W-1:0] rm_idx,
    output logic         head_vld,
    output logic [W-1:0] head_idx
);

    localparam int QW = DEPTH * W;
    localparam int CW = $clog2(DEPTH + 1);

    logic [QW-1:0] q, q_n;
    logic [CW-1:0] cnt, cnt_n;

    // Next queue contents: remove first, then append in priority order.
    always_comb begin
        int          fill;
        logic        found;
        logic [QW-1:0] keep_lo;
        q_n     = q;
        fill    = int'(cnt);
        found   = 1'b0;
        keep_lo = '0;
        if (rm_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (!found && (j < fill) && (q[j*W +: W] == rm_idx)) begin
                    keep_lo = {QW{1'b1}} >> (QW - j*W);
                    q_n     = (q & keep_lo) | ((q >> W) & ~keep_lo);
                    found   = 1'b1;
                end
            end
        end
        if (found) fill = fill - 1;
        for (int s = N - 1; s >= 0; s--) begin
            if (push_mask[s] && (fill < DEPTH)) begin
                q_n  = q_n | (QW'(s) << (fill * W));
                fill = fill + 1;
            end
        end
        cnt_n = CW'(fill);
    end

    // Store the queue and its fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            cnt <= '0;
        end else begin
            q   <= q_n;
            cnt <= cnt_n;
        end
    end

    // The head is the oldest entry.
    always_comb begin
        head_vld = (cnt != '0);
        head_idx = q[W-1:0];
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
// Module: interrupt controller with sequential and nested service modes.
// Edges on the source lines set pending bits. An accepted acknowledge
// moves the offered source into the in-service set. End-of-service clears
// the highest in-service bit. Sequential mode offers the oldest pending
// source when nothing is in service. Nested mode offers the highest pending
// source when it outranks everything in service.
// Assumes: the higher source index has the higher priority, and
// mode_nested changes only while the controller is idle.
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int VW     = $clog2(NSRC),
    parameter int QDEPTH = NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_nested,
    input  logic [NSRC-1:0] irq_src,
    output logic            cpu_irq,
    output logic [VW-1:0]   cpu_vec,
    input  logic            cpu_ack,
    input  logic            cpu_eoi,
    output logic            svc_active,
    output logic [VW-1:0]   svc_level
);

    svc_mode_e       mode;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] pend, pend_n;
    logic [NSRC-1:0] isr, isr_n;
    logic            p_any, s_any;
    logic [VW-1:0]   p_idx, s_idx;
    logic [NSRC-1:0] p_oh, s_oh;
    logic            q_vld;
    logic [VW-1:0]   q_head;
    logic            seq_elig, nest_elig, take;
    logic [NSRC-1:0] take_oh, push;

    // Decode the configuration bit into the mode type.
    always_comb mode = svc_mode_e'(mode_nested);

    irq_edge_det #(.N(NSRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (irq_src),
        .rise  (rise)
    );

    irq_prio_enc #(.N(NSRC), .W(VW)) u_pend_enc (
        .vec    (pend),
        .any    (p_any),
        .idx    (p_idx),
        .onehot (p_oh)
    );

    irq_prio_enc #(.N(NSRC), .W(VW)) u_isr_enc (
        .vec    (isr),
        .any    (s_any),
        .idx    (s_idx),
        .onehot (s_oh)
    );

    irq_arrival_queue #(.N(NSRC), .W(VW), .DEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_mask (push),
        .rm_en     (take),
        .rm_idx    (cpu_vec),
        .head_vld  (q_vld),
        .head_idx  (q_head)
    );

    // Work out whether a request can be offered in each mode, and pick its vector.
    always_comb begin
        seq_elig  = q_vld && !s_any;
        nest_elig = p_any && (!s_any || (p_idx > s_idx));
        if (mode == SVC_NESTED) begin
            cpu_irq = nest_elig;
            cpu_vec = nest_elig ? p_idx : '0;
        end else begin
            cpu_irq = seq_elig;
            cpu_vec = seq_elig ? q_head : '0;
        end
    end

    // Work out the acknowledge transfer and the next pending and in-service sets.
    always_comb begin
        take    = cpu_ack && cpu_irq;
        take_oh = take ? (NSRC'(1) << cpu_vec) : '0;
        push    = rise & (~pend | take_oh);
        pend_n  = (pend & ~take_oh) | rise;
        isr_n   = (cpu_eoi ? (isr & ~s_oh) : isr) | take_oh;
    end

    // Store the pending and in-service sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            isr  <= '0;
        end else begin
            pend <= pend_n;
            isr  <= isr_n;
        end
    end

    // Show the top of the in-service stack.
    always_comb begin
        svc_active = s_any;
        svc_level  = s_idx;
    end

endmodule

// File: rtl/irq_nest_chk.sv
// Module: assertion checker for irq_nest_ctrl. It watches the ports only,
// and a bind statement attaches it to every instance.
// Assumes: the same parameters as the controller it is bound to.
module irq_nest_chk #(
    parameter int NSRC = 4,
    parameter int VW   = $clog2(NSRC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mode_nested,
    input logic            cpu_irq,
    input logic [VW-1:0]   cpu_vec,
    input logic            cpu_ack,
    input logic            cpu_eoi,
    input logic            svc_active,
    input logic [VW-1:0]   svc_level
);

    // R4: no request is offered while sequential service is busy
    a_r4_seq_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_nested && svc_active) |-> !cpu_irq);

    // R7: a nested offer always outranks the active level
    a_r7_nest_outranks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_nested && svc_active && cpu_irq) |-> (cpu_vec > svc_level));

    // R9: an accepted acknowledge puts the offered vector on top
    a_r9_ack_to_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_irq && !cpu_eoi) |=> (svc_active && (svc_level == $past(cpu_vec))));

    // R8: end-of-service lowers the top level or empties the stack
    a_r8_eoi_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_eoi && !cpu_ack && svc_active) |=> (!svc_active || (svc_level < $past(svc_level))));

    // R11: without an accept or end-of-service, the service state holds
    a_r11_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cpu_ack && cpu_irq) && !cpu_eoi) |=> ($stable(svc_active) && $stable(svc_level)));

endmodule

bind irq_nest_ctrl irq_nest_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_nested (mode_nested),
    .cpu_irq     (cpu_irq),
    .cpu_vec     (cpu_vec),
    .cpu_ack     (cpu_ack),
    .cpu_eoi     (cpu_eoi),
    .svc_active  (svc_active),
    .svc_level   (svc_level)
);

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
module tb_irq_nest_ctrl;

    localparam int NSRC = 4;
    localparam int VW   = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            mode;
    logic [NSRC-1:0] src;
    logic            irq;
    logic [VW-1:0]   vec;
    logic            ack;
    logic            eoi;
    logic            act;
    logic [VW-1:0]   lvl;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_nest_ctrl #(.NSRC(NSRC)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_nested (mode),
        .irq_src     (src),
        .cpu_irq     (irq),
        .cpu_vec     (vec),
        .cpu_ack     (ack),
        .cpu_eoi     (eoi),
        .svc_active  (act),
        .svc_level   (lvl)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int actual, input int expected);
        n_vec++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic ack_pulse();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic eoi_pulse();
        eoi = 1'b1; tick(); eoi = 1'b0;
    endtask

    function automatic int top_bit(input int m);
        int r = -1;
        for (int i = 0; i < NSRC; i++) if (m[i]) r = i;
        return r;
    endfunction

    // Serve every source in the mask in descending index order.
    task automatic serve_desc(input int m, input string tag);
        int rem = m;
        while (rem != 0) begin
            int e = top_bit(rem);
            chk({tag, " offer"}, irq, 1);
            chk({tag, " vector"}, vec, e);
            ack_pulse();
            chk("R9 level after ack", lvl, e);
            chk("R4/R7 lower waits", irq, 0);
            eoi_pulse();
            chk("R8 stack empty", act, 0);
            rem = rem & ~(1 << e);
        end
        chk({tag, " drained"}, irq, 0);
        chk("R3 idle vector", vec, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int ord[4];
        rst_n = 1'b0; mode = 1'b0; src = '0; ack = 1'b0; eoi = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 irq after reset", irq, 0);
        chk("R1 vec after reset", vec, 0);
        chk("R1 active after reset", act, 0);

        // R9: an acknowledge with no request is ignored.
        ack_pulse();
        chk("R9 idle ack ignored", act, 0);

        // R5 R4: every arrival order of the four sources, sequential mode.
        mode = 1'b0;
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
        for (int d = 0; d < 4; d++) begin
            if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
            ord[0] = a; ord[1] = b; ord[2] = c; ord[3] = d;
            for (int i = 0; i < 4; i++) begin
                src[ord[i]] = 1'b1;
                tick();
            end
            src = '0;
            tick();
            for (int i = 0; i < 4; i++) begin
                chk("R5 offer", irq, 1);
                chk("R5 arrival order", vec, ord[i]);
                ack_pulse();
                chk("R9 level after ack", lvl, ord[i]);
                chk("R9 active after ack", act, 1);
                chk("R4 held while busy", irq, 0);
                ack_pulse();
                chk("R9 ack ignored when idle line", lvl, ord[i]);
                chk("R11 active holds", act, 1);
                eoi_pulse();
                chk("R8 eoi clears", act, 0);
            end
            chk("R5 drained", irq, 0);
        end

        // R6 R10: simultaneous edges for every mask, both modes.
        for (int md = 0; md < 2; md++) begin
            mode = md[0];
            for (int m = 1; m < 16; m++) begin
                src = NSRC'(m);
                tick();
                src = '0;
                tick();
                serve_desc(m, md == 0 ? "R6 simultaneous" : "R10 nested highest");
            end
        end

        // R7 R8: nested mode, every pair of running level and newcomer.
        mode = 1'b1;
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
            src[a] = 1'b1; tick(); src = '0; tick();
            chk("R10 first offer", vec, a);
            ack_pulse();
            chk("R9 running level", lvl, a);
            src[b] = 1'b1; tick(); src = '0; tick();
            if (b > a) begin
                chk("R7 preempt offer", irq, 1);
                chk("R7 preempt vector", vec, b);
                ack_pulse();
                chk("R7 preempt level", lvl, b);
                chk("R7 nothing above", irq, 0);
                eoi_pulse();
                chk("R8 resumes active", act, 1);
                chk("R8 resumes level", lvl, a);
                eoi_pulse();
                chk("R8 stack empty", act, 0);
            end else begin
                chk("R7 lower or equal waits", irq, 0);
                eoi_pulse();
                chk("R8 stack empty", act, 0);
                chk("R7 waiting offer", irq, 1);
                chk("R7 waiting vector", vec, b);
                ack_pulse();
                chk("R9 waiting level", lvl, b);
                eoi_pulse();
                chk("R8 stack empty", act, 0);
            end
            chk("R3 idle vector", vec, 0);
        end

        // R2: a line held high is not latched again after service.
        mode = 1'b0;
        src[2] = 1'b1; tick();
        chk("R2 edge latched", irq, 1);
        chk("R2 edge vector", vec, 2);
        ack_pulse();
        eoi_pulse();
        tick(); tick();
        chk("R2 held line not relatched", irq, 0);
        src[2] = 1'b0; tick();
        src[2] = 1'b1; tick();
        chk("R2 new edge latched", irq, 1);
        chk("R2 new edge vector", vec, 2);
        ack_pulse();
        eoi_pulse();
        src = '0;
        tick();
        chk("R2 final idle", irq, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule